// File: doc/BRIEF.md
# Coefficient Load Port

This block is the write-only path by which a host fills a filter's coefficient memory and its control word. It runs on the system clock. Each rising edge samples an active-low chip select and write enable, a control-select line, an 8-bit address, a 16-bit data bus and a byte/word mode input. There is no read path toward the host. For observation, a side port returns any stored coefficient combinationally.

A coefficient arrives either as one 16-bit word or as two byte writes, low byte first. In byte mode each write must pass a nibble-equality check on the upper data bits. The block also enforces the loading order. After reset a busy output stays high for a fixed number of cycles. The control word must then be loaded, with chip select held low for two extra cycles. One idle cycle must follow before any coefficient write. A coefficient write that breaks this order is dropped and sets a sticky error flag.

The controller has five states:
- `ST_NOCTL` is the reset state: no control word has been loaded yet.
- `ST_HOLD1` and `ST_HOLD2` count the two select-hold cycles.
- `ST_GAP` is the enforced idle cycle.
- `ST_READY` accepts coefficient writes.

Its transitions are:
- load-start: `ST_NOCTL`, `ST_GAP` or `ST_READY` go to `ST_HOLD1` on a control write.
- hold-continue: `ST_HOLD1` goes to `ST_HOLD2` while select stays low.
- commit: `ST_HOLD2` goes to `ST_GAP` while select stays low.
- gap-expire: `ST_GAP` goes to `ST_READY`.
- abort: `ST_HOLD1` or `ST_HOLD2` return to `ST_READY` if a control word was loaded earlier, otherwise to `ST_NOCTL`, when select rises early.

Top module: `coef_load_port`

## Requirements
- R1: While `rst_n` is low, `busy` is 1, `order_err` is 0, `ctrl_q` is 0 and `wr_done` is 0.
- R2: After `rst_n` rises, `busy` stays 1 for exactly 22 clock cycles, then falls and stays 0 until the next reset.
- R3: A write is taken only on an edge where `cs_n` and `we_n` are both sampled 0. An edge with only one of them low changes no memory location and raises no `wr_done`.
- R4: A control write (`ctl_sel`=1) loads `wdata` into `ctrl_q` only if `cs_n` is also sampled low on the two following edges. `ctrl_q` changes on the third of those edges. If `cs_n` rises earlier, `ctrl_q` keeps its old value and the block does not count as loaded.
- R5: A coefficient write (`ctl_sel`=0) sampled while `busy` is 1 is dropped and sets `order_err`.
- R6: A coefficient write before any control word has been committed since reset is dropped and sets `order_err`.
- R7: A coefficient write sampled on the edge right after the control commit edge (the gap cycle) is dropped and sets `order_err`. A write one cycle later is accepted.
- R8: In word mode (`byte_mode`=0), `addr[6:0]` selects one of 128 locations and `addr[7]` is ignored. The 16-bit `wdata` is stored. `wr_done` is 1 for exactly the one cycle after the write edge.
- R9: In byte mode (`byte_mode`=1), the coefficient index is `addr[7:1]`. A write with `addr[0]`=0 stages `wdata[7:0]` as the low byte and writes no memory. A following write with `addr[0]`=1 and the same index stores {`wdata[7:0]`, staged byte}. A high write that has no staged low byte for that index is dropped. Every high write clears the staged byte.
- R10: In byte mode, a write whose `wdata[15:12]` differs from `wdata[11:8]` is dropped without setting `order_err`.
- R11: `order_err` stays 1 once set, through later legal writes, until reset.
- R12: `peek_data` shows the stored coefficient at `peek_addr` in the same cycle. Reset does not clear the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| ctl_sel | input | 1 | 1 targets the control word, 0 targets coefficient memory |
| byte_mode | input | 1 | 1 selects byte-pair loading, 0 selects word loading |
| addr | input | 8 | Coefficient address |
| wdata | input | 16 | Write data |
| peek_addr | input | 7 | Observation index into coefficient memory |
| peek_data | output | 16 | Stored coefficient at `peek_addr` |
| busy | output | 1 | High during the post-reset busy period |
| ctrl_q | output | 16 | Committed control word |
| wr_done | output | 1 | One-cycle pulse after a coefficient is stored |
| order_err | output | 1 | Sticky flag for a coefficient write that broke the loading order |

## Verification
The bench probes the two timing windows around the control word.
- A coefficient write placed in the gap cycle must be rejected. A design that counted the gap one edge late or early would store it or reject a legal write.
- A control write whose select rises after one cycle must leave `ctrl_q` untouched. A design that committed on the first edge would accept it.
In byte mode the bench sends the following, each against the stored value:
- a low byte on its own
- a high byte with no staged low byte
- writes that fail the nibble check
A design that wrote half-words directly, or that checked nibbles only on high bytes, would corrupt the stored coefficient. The bench also sets `addr[7]` in word mode to catch a design that decodes that bit.

// File: rtl/clp_pkg.sv
package clp_pkg;
    typedef enum logic [2:0] {
        ST_NOCTL = 3'd0,
        ST_HOLD1 = 3'd1,
        ST_HOLD2 = 3'd2,
        ST_GAP   = 3'd3,
        ST_READY = 3'd4
    } clp_state_e;
endpackage

// File: rtl/clp_busy_timer.sv
module clp_busy_timer #(
    parameter int BUSY_CYCLES = 22
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= CW'(BUSY_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/clp_byte_stager.sv
module clp_byte_stager #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode,
    input  logic              en,
    input  logic [ADDR_W:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] data
);
    localparam int HALF = DATA_W / 2;
    localparam int QTR  = DATA_W / 4;

    logic              nib_ok;
    logic              hi_sel;
    logic [ADDR_W-1:0] pair_idx;
    logic [HALF-1:0]   st_lo;
    logic [ADDR_W-1:0] st_idx;
    logic              st_v;

    assign nib_ok   = (wdata[DATA_W-1 -: QTR] == wdata[DATA_W-QTR-1 -: QTR]);
    assign hi_sel   = addr[0];
    assign pair_idx = addr[ADDR_W:1];

    always_comb begin
        if (byte_mode) begin
            commit = en && hi_sel && nib_ok && st_v && (st_idx == pair_idx);
            idx    = pair_idx;
            data   = {wdata[HALF-1:0], st_lo};
        end else begin
            commit = en;
            idx    = addr[ADDR_W-1:0];
            data   = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_lo  <= '0;
            st_idx <= '0;
            st_v   <= 1'b0;
        end else if (en && byte_mode) begin
            if (!hi_sel) begin
                if (nib_ok) begin
                    st_lo  <= wdata[HALF-1:0];
                    st_idx <= pair_idx;
                    st_v   <= 1'b1;
                end
            end else begin
                st_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clp_coef_ram.sv
module clp_coef_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/coef_load_port.sv
module coef_load_port #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              ctl_sel,
    input  logic              byte_mode,
    input  logic [ADDR_W:0]   addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic              busy,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              wr_done,
    output logic              order_err
);
    import clp_pkg::*;

    clp_state_e        state, state_nx;
    logic              ctl_valid;
    logic [DATA_W-1:0] ctl_shadow;
    logic              wr_strobe, coef_req, ctl_req;
    logic              coef_go, err_set, ctl_load, ctl_commit;
    logic              stg_commit;
    logic [ADDR_W-1:0] stg_idx;
    logic [DATA_W-1:0] stg_data;

    assign wr_strobe = !cs_n && !we_n;
    assign coef_req  = wr_strobe && !ctl_sel;
    assign ctl_req   = wr_strobe && ctl_sel;

    clp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_NOCTL;
        end else begin
            state <= state_nx;
        end
    end

    // next state and per-cycle controls
    always_comb begin
        state_nx   = state;
        coef_go    = 1'b0;
        err_set    = 1'b0;
        ctl_load   = 1'b0;
        ctl_commit = 1'b0;
        if (busy) begin
            err_set = coef_req;
        end else begin
            unique case (state)
                ST_NOCTL: begin
                    if (ctl_req) begin
                        state_nx = ST_HOLD1;
                        ctl_load = 1'b1;
                    end else begin
                        err_set = coef_req;
                    end
                end
                ST_HOLD1: begin
                    if (cs_n) state_nx = ctl_valid ? ST_READY : ST_NOCTL;
                    else      state_nx = ST_HOLD2;
                end
                ST_HOLD2: begin
                    if (cs_n) begin
                        state_nx = ctl_valid ? ST_READY : ST_NOCTL;
                    end else begin
                        state_nx   = ST_GAP;
                        ctl_commit = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (ctl_req) begin
                        state_nx = ST_HOLD1;
                        ctl_load = 1'b1;
                    end else begin
                        state_nx = ST_READY;
                        err_set  = coef_req;
                    end
                end
                ST_READY: begin
                    if (ctl_req) begin
                        state_nx = ST_HOLD1;
                        ctl_load = 1'b1;
                    end else begin
                        coef_go = coef_req;
                    end
                end
                default: state_nx = ST_NOCTL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_valid  <= 1'b0;
            ctl_shadow <= '0;
            ctrl_q     <= '0;
            order_err  <= 1'b0;
            wr_done    <= 1'b0;
        end else begin
            if (ctl_load)   ctl_shadow <= wdata;
            if (ctl_commit) begin
                ctrl_q    <= ctl_shadow;
                ctl_valid <= 1'b1;
            end
            if (err_set)    order_err <= 1'b1;
            wr_done <= stg_commit;
        end
    end

    clp_byte_stager #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .en        (coef_go),
        .addr      (addr),
        .wdata     (wdata),
        .commit    (stg_commit),
        .idx       (stg_idx),
        .data      (stg_data)
    );

    clp_coef_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (stg_commit),
        .waddr (stg_idx),
        .wdata (stg_data),
        .raddr (peek_addr),
        .rdata (peek_data)
    );
endmodule

// File: rtl/clp_checker.sv
module clp_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              we_n,
    input logic              ctl_sel,
    input logic              busy,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              wr_done,
    input logic              order_err
);
    assert_busy_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy));

    assert_done_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(!cs_n && !we_n && !ctl_sel));

    assert_ctl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> ($past(!cs_n, 1) && $past(!cs_n, 2) && $past(!cs_n, 3)));

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !$past(busy));

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(order_err) |-> $past(!cs_n && !we_n && !ctl_sel));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |=> order_err);
endmodule

bind coef_load_port clp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .ctl_sel   (ctl_sel),
    .busy      (busy),
    .ctrl_q    (ctrl_q),
    .wr_done   (wr_done),
    .order_err (order_err)
);

// File: tb/sim_coef_load_port.sv
module sim_coef_load_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        we_n = 1'b1;
    logic        ctl_sel = 1'b0;
    logic        byte_mode = 1'b0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [6:0]  peek_addr = '0;
    logic [15:0] peek_data;
    logic        busy;
    logic [15:0] ctrl_q;
    logic        wr_done;
    logic        order_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_load_port u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .ctl_sel(ctl_sel),
        .byte_mode(byte_mode), .addr(addr), .wdata(wdata), .peek_addr(peek_addr),
        .peek_data(peek_data), .busy(busy), .ctrl_q(ctrl_q), .wr_done(wr_done),
        .order_err(order_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek_chk(input string req, input logic [6:0] idx, input logic [15:0] exp);
        peek_addr = idx;
        #1;
        chk(req, 32'(peek_data), 32'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic coef_wr(input logic [7:0] a, input logic [15:0] d);
        cs_n = 1'b0; we_n = 1'b0; ctl_sel = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic ctl_wr(input logic [15:0] d, input int hold);
        cs_n = 1'b0; we_n = 1'b0; ctl_sel = 1'b1; wdata = d;
        @(negedge clk);
        we_n = 1'b1;
        repeat (hold) @(negedge clk);
        cs_n = 1'b1; ctl_sel = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        chk("R1 busy", 32'(busy), 1);
        chk("R1 order_err", 32'(order_err), 0);
        chk("R1 ctrl_q", 32'(ctrl_q), 0);
        chk("R1 wr_done", 32'(wr_done), 0);
    endtask

    task automatic t_busy_len();
        int n;
        rst_n = 1'b1;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk("R2 busy length", 32'(n), 22);
        idle(5);
        chk("R2 busy stays low", 32'(busy), 0);
    endtask

    task automatic t_busy_refuse();
        do_reset();
        idle(2);
        coef_wr(8'h03, 16'h1111);
        chk("R5 no write while busy", 32'(wr_done), 0);
        chk("R5 err while busy", 32'(order_err), 1);
    endtask

    task automatic t_word_load();
        do_reset();
        idle(22);
        chk("R6 no err yet", 32'(order_err), 0);
        ctl_wr(16'hA5C3, 2);
        chk("R4 ctrl committed", 32'(ctrl_q), 32'h0000A5C3);
        idle(1);
        byte_mode = 1'b0;
        coef_wr(8'h05, 16'h1234);
        chk("R8 wr_done pulse", 32'(wr_done), 1);
        peek_chk("R12 word stored", 7'h05, 16'h1234);
        idle(1);
        chk("R8 wr_done one cycle", 32'(wr_done), 0);
        coef_wr(8'h8A, 16'hBEEF);
        peek_chk("R8 addr bit7 ignored", 7'h0A, 16'hBEEF);
        // R3: select low with write enable high
        cs_n = 1'b0; we_n = 1'b1; addr = 8'h05; wdata = 16'hFFFF;
        @(negedge clk);
        cs_n = 1'b1;
        chk("R3 no done cs only", 32'(wr_done), 0);
        peek_chk("R3 mem kept cs only", 7'h05, 16'h1234);
        // R3: write enable low with select high
        cs_n = 1'b1; we_n = 1'b0; wdata = 16'hEEEE;
        @(negedge clk);
        we_n = 1'b1;
        peek_chk("R3 mem kept we only", 7'h05, 16'h1234);
        chk("R6 legal load no err", 32'(order_err), 0);
    endtask

    task automatic t_byte_load();
        byte_mode = 1'b1;
        coef_wr(8'h10, 16'h0077);
        chk("R9 low byte no write", 32'(wr_done), 0);
        coef_wr(8'h11, 16'h0066);
        chk("R9 pair done", 32'(wr_done), 1);
        peek_chk("R9 pair stored", 7'h08, 16'h6677);
        coef_wr(8'h20, 16'h5511);
        coef_wr(8'h21, 16'hAA22);
        peek_chk("R10 equal nibbles pass", 7'h10, 16'h2211);
        coef_wr(8'h10, 16'h0099);
        coef_wr(8'h11, 16'h1F33);
        chk("R10 high nibble fail no done", 32'(wr_done), 0);
        peek_chk("R10 high nibble fail kept", 7'h08, 16'h6677);
        coef_wr(8'h10, 16'h3C44);
        coef_wr(8'h11, 16'h0055);
        peek_chk("R9 orphan high dropped", 7'h08, 16'h6677);
        coef_wr(8'h10, 16'h0012);
        coef_wr(8'h13, 16'h0034);
        peek_chk("R9 index mismatch dropped", 7'h09, 16'hXXXX);
        peek_chk("R9 index mismatch kept", 7'h08, 16'h6677);
        chk("R10 no err from nibble", 32'(order_err), 0);
        byte_mode = 1'b0;
    endtask

    task automatic t_gap();
        do_reset();
        chk("R1 ctrl cleared", 32'(ctrl_q), 0);
        idle(22);
        ctl_wr(16'h0001, 2);
        coef_wr(8'h05, 16'h5555);
        chk("R7 gap refused", 32'(wr_done), 0);
        chk("R7 gap err", 32'(order_err), 1);
        peek_chk("R12 survives reset", 7'h05, 16'h1234);
        idle(1);
        coef_wr(8'h06, 16'h6666);
        chk("R7 after gap accepted", 32'(wr_done), 1);
        chk("R11 err sticky", 32'(order_err), 1);
    endtask

    task automatic t_no_ctl();
        do_reset();
        idle(22);
        coef_wr(8'h0A, 16'h0000);
        chk("R6 err before ctl", 32'(order_err), 1);
        peek_chk("R6 write dropped", 7'h0A, 16'hBEEF);
    endtask

    task automatic t_ctl_abort();
        do_reset();
        idle(22);
        ctl_wr(16'h7777, 0);
        idle(3);
        chk("R4 abort keeps ctrl", 32'(ctrl_q), 0);
        coef_wr(8'h05, 16'h4321);
        chk("R4 abort not loaded", 32'(order_err), 1);
        peek_chk("R4 abort write dropped", 7'h05, 16'h1234);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_busy_len();
        t_busy_refuse();
        t_word_load();
        t_byte_load();
        t_gap();
        t_no_ctl();
        t_ctl_abort();
        idle(2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule